// File: doc/BRIEF.md
# FIFO-Buffered SPI Master Controller

A memory-mapped SPI master that serializes words of 8, 16 or 32 bits. Software configures it through four registers (control, status, data and divisor). Each register can be reached at three addresses: a plain write, a write-one-to-clear alias and a write-one-to-set alias. Writes to the data register queue words in a transmit FIFO. Reads of the data register take words out of a receive FIFO. Both FIFOs share a 16-byte budget per direction, so they hold 16, 8 or 4 words depending on the selected width.

The serial clock runs at the input clock divided by 2×(divisor+1). Its idle level, the edge on which output data changes, and the point at which input data is captured are all programmable. Every word sent returns exactly one received word. A receive word that finds its FIFO full is dropped, and this raises a sticky overflow flag. An optional automatic slave-select output stays low while the transmit FIFO holds any word, including the one being shifted.

The bus address is four bits. Bits 3:2 pick the register: 0 control, 1 status, 2 data, 3 divisor. Bits 1:0 pick the access: 0 plain, 1 clear alias, 2 set alias, 3 no effect.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, the control, status and divisor registers read 0, `sck` is 0 and `ss_n` is 1.
- R2: During a word, each half period of `sck` lasts exactly divisor+1 input clocks. The divisor is the 9-bit register at index 3.
- R3: Control bits 11:10 select the width: 00 gives 8 bits, 01 gives 16 bits, 10 gives 32 bits. A word produces 2×width `sck` edges and shifts out the low width bits of the written value, most-significant bit first.
- R4: Control bit 6 sets the idle level of `sck`: 1 makes it idle high, 0 makes it idle low.
- R5: Control bit 8 set: `mosi` changes on trailing edges and is valid at every leading edge. Bit 8 clear: `mosi` changes on leading edges and is valid at every trailing edge.
- R6: Each word received is the width bits sampled from `miso`, right-aligned with zeros above. Control bit 9 clear samples in the middle of each bit. Bit 9 set samples at the end of each bit. Data is correct in all four combinations of bits 8 and 9.
- R7: With control bit 16 set, each FIFO holds 16, 8 or 4 words at 8, 16 or 32 bits. With bit 16 clear, each FIFO holds one word. Writes to a full transmit FIFO are ignored. Status bits 20:16 give the transmit level and bits 28:24 give the receive level. Words leave in the order they arrived.
- R8: Status bit 6 becomes 1 when a received word finds the receive FIFO full. That word is discarded. The bit stays 1, even across data reads, until a status write clears it.
- R9: A write at access 1 clears the register bits written as 1. A write at access 2 sets the register bits written as 1. All other bits keep their value.
- R10: With control bit 28 set, `ss_n` is 0 exactly while the transmit level is nonzero, so it covers the whole of the last word. With bit 28 clear, `ss_n` stays 1.
- R11: Words are shifted only while control bit 15 (enable) and bit 5 (master) are both 1. Clearing bit 15 empties both FIFOs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a data read takes one receive word) |
| bus_addr | input | 4 | Register index in bits 3:2, access kind in bits 1:0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Automatic slave select, active low |

## Verification
The assertions assume that width, enhanced-buffer and divisor settings change only while the enable bit is clear, or while both FIFOs are empty. Under that assumption the FIFO levels never exceed the capacity the settings imply. They also assume `miso` is driven to a known level whenever the clock runs. The stimulus keeps to this: every reconfiguration first writes zero to the control register, then writes the new value. The bench ties `miso` to the inverse of `mosi`, so the expected received word is always the complement of the sent word.

// File: rtl/spi_pkg.sv
package spi_pkg;
    localparam int CTRL_MASTER  = 5;
    localparam int CTRL_IDLE_HI = 6;
    localparam int CTRL_EARLY   = 8;
    localparam int CTRL_LATE    = 9;
    localparam int CTRL_WS_LO   = 10;
    localparam int CTRL_ON      = 15;
    localparam int CTRL_DEEP    = 16;
    localparam int CTRL_AUTOSS  = 28;
    localparam int STAT_OVF     = 6;
    localparam int STAT_TXL_LO  = 16;
    localparam int STAT_RXL_LO  = 24;

    typedef enum logic [1:0] {
        ACC_RAW  = 2'd0,
        ACC_CLR  = 2'd1,
        ACC_SET  = 2'd2,
        ACC_NONE = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DATA = 2'd2,
        SEL_DIV  = 2'd3
    } sel_e;

    function automatic int ws_bits(input logic [1:0] ws);
        case (ws)
            2'd0:    return 8;
            2'd1:    return 16;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] acc_apply(input logic [31:0] old,
                                              input logic [31:0] wd,
                                              input acc_e a);
        case (a)
            ACC_RAW: return wd;
            ACC_CLR: return old & ~wd;
            ACC_SET: return old | wd;
            default: return old;
        endcase
    endfunction
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
    parameter int DIVW = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] divisor,
    output logic            tick
);
    logic [DIVW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        tick  = run && (cnt_q == divisor);
        if (run && !tick) cnt_d = cnt_q + DIVW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
    parameter int ENTRIES = 16,
    parameter int W       = 32,
    parameter int LVLW    = $clog2(ENTRIES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            push,
    input  logic            pop,
    input  logic [LVLW-1:0] cap,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    rdata,
    output logic [LVLW-1:0] level,
    output logic            full,
    output logic            empty
);
    localparam int PTRW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [PTRW-1:0] wp;
        logic [PTRW-1:0] rp;
        logic [LVLW-1:0] lvl;
    } fifo_t;

    fifo_t           d, q;
    logic [W-1:0]    mem [ENTRIES];
    logic            push_ok, pop_ok;

    function automatic logic [PTRW-1:0] nxt(input logic [PTRW-1:0] p);
        return (int'(p) == ENTRIES - 1) ? '0 : p + PTRW'(1);
    endfunction

    assign level   = q.lvl;
    assign empty   = (q.lvl == '0);
    assign full    = (q.lvl >= cap);
    assign rdata   = mem[q.rp];
    assign push_ok = push && !full && !flush;
    assign pop_ok  = pop && !empty && !flush;

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (push_ok) d.wp = nxt(q.wp);
            if (pop_ok)  d.rp = nxt(q.rp);
            if (push_ok && !pop_ok)      d.lvl = q.lvl + LVLW'(1);
            else if (pop_ok && !push_ok) d.lvl = q.lvl - LVLW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[q.wp] <= wdata;
    end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_pkg::*;
#(
    parameter int WORDW = 32,
    parameter int HALFW = $clog2(2 * WORDW + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       ws,
    input  logic             idle_hi,
    input  logic             early,
    input  logic             late,
    input  logic             tick,
    input  logic             tx_avail,
    input  logic [WORDW-1:0] tx_word,
    input  logic             miso,
    output logic             busy,
    output logic             done,
    output logic             sck,
    output logic             mosi,
    output logic [WORDW-1:0] rx_word
);
    localparam int IDXW = $clog2(WORDW);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [HALFW-1:0] half;
        logic             sck;
        logic [WORDW-1:0] tx_sh;
        logic [WORDW-1:0] rx_sh;
    } eng_t;

    eng_t             d, q;
    int               nbits, total;
    logic             odd, first, shift_now, samp_now;
    logic [WORDW-1:0] mask;

    always_comb begin
        nbits = ws_bits(ws);
        total = 2 * nbits + ((late && !early) ? 1 : 0);
        mask  = (nbits >= WORDW) ? '1 : ((WORDW'(1) << nbits) - WORDW'(1));
        odd   = q.half[0];
        first = (q.half == '0);
        // output change: trailing edges when early, else leading edges after the first
        shift_now = early ? odd : (!odd && !first);
        // capture: opposite edge mid-bit, or at the next change point when late
        if (early) samp_now = late ? odd : !odd;
        else       samp_now = late ? (!odd && !first) : odd;

        d      = q;
        d.done = 1'b0;
        if (!enable) begin
            d.busy = 1'b0;
            d.sck  = idle_hi;
        end else if (!q.busy) begin
            d.sck = idle_hi;
            if (tx_avail && !q.done) begin
                d.busy  = 1'b1;
                d.half  = '0;
                d.tx_sh = tx_word;
                d.rx_sh = '0;
            end
        end else if (tick) begin
            if (int'(q.half) < 2 * nbits) d.sck = ~q.sck;
            if (shift_now) d.tx_sh = q.tx_sh << 1;
            if (samp_now)  d.rx_sh = {q.rx_sh[WORDW-2:0], miso};
            if (int'(q.half) == total - 1) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.half = q.half + HALFW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign done    = q.done;
    assign sck     = q.sck;
    assign mosi    = q.tx_sh[IDXW'(nbits - 1)];
    assign rx_word = q.rx_sh & mask;
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spi_pkg::*;
#(
    parameter int DATAW     = 32,
    parameter int DIVW      = 9,
    parameter int FIFO_BYTE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [3:0]       bus_addr,
    input  logic [DATAW-1:0] bus_wdata,
    output logic [DATAW-1:0] bus_rdata,
    output logic             sck,
    output logic             mosi,
    input  logic             miso,
    output logic             ss_n
);
    localparam int LVLW = $clog2(FIFO_BYTE + 1);
    localparam logic [31:0] CTRL_WMASK =
        (32'd1 << CTRL_MASTER) | (32'd1 << CTRL_IDLE_HI) | (32'd1 << CTRL_EARLY) |
        (32'd1 << CTRL_LATE) | (32'd3 << CTRL_WS_LO) | (32'd1 << CTRL_ON) |
        (32'd1 << CTRL_DEEP) | (32'd1 << CTRL_AUTOSS);

    typedef struct packed {
        logic [31:0]     ctrl;
        logic [DIVW-1:0] baud;
        logic            ovf;
    } regs_t;

    regs_t d, q;

    sel_e  sel;
    acc_e  acc;
    logic  on, master, deep, autoss;
    logic [1:0] ws;
    logic [LVLW-1:0] cap, tx_lvl, rx_lvl;
    logic  tx_push, tx_full, tx_empty, rx_pop, rx_push, rx_full, rx_empty;
    logic  eng_busy, eng_done, tick, flush;
    logic [DATAW-1:0] tx_head, rx_head, rx_word;
    logic [31:0] stat_word, ovf_w;

    assign sel    = sel_e'(bus_addr[3:2]);
    assign acc    = acc_e'(bus_addr[1:0]);
    assign on     = q.ctrl[CTRL_ON];
    assign master = q.ctrl[CTRL_MASTER];
    assign deep   = q.ctrl[CTRL_DEEP];
    assign autoss = q.ctrl[CTRL_AUTOSS];
    assign ws     = q.ctrl[CTRL_WS_LO +: 2];
    assign flush  = !on;

    always_comb begin
        int shamt;
        shamt = (ws == 2'd3) ? 2 : int'(ws);
        cap   = deep ? LVLW'(FIFO_BYTE >> shamt) : LVLW'(1);
    end

    assign tx_push = bus_wr && sel == SEL_DATA && acc == ACC_RAW && on;
    assign rx_pop  = bus_rd && sel == SEL_DATA && acc == ACC_RAW;
    assign rx_push = eng_done && !rx_full;

    always_comb begin
        stat_word = '0;
        stat_word[STAT_OVF] = q.ovf;
        stat_word[STAT_TXL_LO +: LVLW] = tx_lvl;
        stat_word[STAT_RXL_LO +: LVLW] = rx_lvl;
    end

    always_comb begin
        d     = q;
        ovf_w = acc_apply(stat_word, bus_wdata, acc);
        if (bus_wr) begin
            case (sel)
                SEL_CTRL: d.ctrl = acc_apply(q.ctrl, bus_wdata, acc) & CTRL_WMASK;
                SEL_STAT: d.ovf  = ovf_w[STAT_OVF];
                SEL_DIV:  d.baud = DIVW'(acc_apply(32'(q.baud), bus_wdata, acc));
                default:  ;
            endcase
        end
        if (eng_done && rx_full) d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (sel)
            SEL_CTRL: bus_rdata = q.ctrl;
            SEL_STAT: bus_rdata = stat_word;
            SEL_DATA: bus_rdata = rx_empty ? '0 : rx_head;
            default:  bus_rdata = DATAW'(q.baud);
        endcase
    end

    assign ss_n = !(autoss && tx_lvl != '0);

    spi_word_fifo #(.ENTRIES(FIFO_BYTE), .W(DATAW), .LVLW(LVLW)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(tx_push), .pop(eng_done),
        .cap(cap), .wdata(bus_wdata), .rdata(tx_head), .level(tx_lvl),
        .full(tx_full), .empty(tx_empty)
    );

    spi_word_fifo #(.ENTRIES(FIFO_BYTE), .W(DATAW), .LVLW(LVLW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(rx_push), .pop(rx_pop),
        .cap(cap), .wdata(rx_word), .rdata(rx_head), .level(rx_lvl),
        .full(rx_full), .empty(rx_empty)
    );

    spi_baud_gen #(.DIVW(DIVW)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(eng_busy), .divisor(q.baud), .tick(tick)
    );

    spi_shift_engine #(.WORDW(DATAW)) u_eng (
        .clk(clk), .rst_n(rst_n), .enable(on && master), .ws(ws),
        .idle_hi(q.ctrl[CTRL_IDLE_HI]), .early(q.ctrl[CTRL_EARLY]),
        .late(q.ctrl[CTRL_LATE]), .tick(tick), .tx_avail(!tx_empty),
        .tx_word(tx_head), .miso(miso), .busy(eng_busy), .done(eng_done),
        .sck(sck), .mosi(mosi), .rx_word(rx_word)
    );
endmodule

// File: rtl/spi_master_chk.sv
module spi_master_chk #(
    parameter int LVLW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sck,
    input logic            ss_n,
    input logic            idle_hi,
    input logic            autoss,
    input logic            on,
    input logic            master,
    input logic            busy,
    input logic            ovf,
    input logic            stat_wr,
    input logic [LVLW-1:0] cap,
    input logic [LVLW-1:0] tx_lvl,
    input logic [LVLW-1:0] rx_lvl
);
    // R4: clock rests at the programmed idle level between words
    assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && $stable(idle_hi)) |-> (sck == idle_hi));

    // R10: slave select held low through every word when automatic select is on
    assert_ss_covers_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (autoss && busy) |-> !ss_n);

    // R7: levels never exceed capacity under settled configuration
    assert_level_in_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cap) |-> (tx_lvl <= cap && rx_lvl <= cap));

    // R8: overflow flag only falls through a status write
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !stat_wr) |=> ovf);

    // R11: no shifting while disabled or not master
    assert_halt_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(on && master) |=> !busy);
endmodule

bind spi_fifo_master spi_master_chk #(.LVLW(LVLW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ss_n(ss_n),
    .idle_hi(q.ctrl[6]), .autoss(autoss), .on(on), .master(master),
    .busy(eng_busy), .ovf(q.ovf), .stat_wr(bus_wr && bus_addr[3:2] == 2'd1),
    .cap(cap), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl)
);

// File: tb/tb_spi_fifo_master.sv
module tb_spi_fifo_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sck, mosi, miso, ss_n;

    localparam logic [3:0] A_CTRL = 4'h0, A_CTRL_CLR = 4'h1, A_CTRL_SET = 4'h2;
    localparam logic [3:0] A_STAT = 4'h4, A_STAT_CLR = 4'h5, A_DATA = 4'h8;
    localparam logic [3:0] A_DIV = 4'hC, A_DIV_CLR = 4'hD, A_DIV_SET = 4'hE;
    localparam logic [31:0] B_ON = 32'h8000, B_MST = 32'h20, B_DEEP = 32'h1_0000;
    localparam logic [31:0] B_AUTO = 32'h1000_0000;

    // vector: ws[45:44] idle_hi[43] early[42] late[41] div[40:32] word[31:0]
    localparam int NV = 7;
    localparam logic [45:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b1, 1'b0, 9'd0, 32'h0000_00A5},
        {2'd0, 1'b1, 1'b0, 1'b1, 9'd2, 32'h0000_003C},
        {2'd1, 1'b0, 1'b0, 1'b0, 9'd1, 32'h0000_BEEF},
        {2'd1, 1'b1, 1'b1, 1'b1, 9'd0, 32'h0000_1234},
        {2'd2, 1'b0, 1'b1, 1'b1, 9'd3, 32'hDEAD_BEEF},
        {2'd2, 1'b1, 1'b0, 1'b0, 9'd0, 32'h8000_0001},
        {2'd0, 1'b0, 1'b1, 1'b1, 9'd1, 32'h1234_56C3}
    };

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    assign miso = ~mosi;

    spi_fifo_master dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    always #10 clk = ~clk;

    // serial monitor, sampled on the falling input-clock edge
    int          cyc = 0, last_edge = 0, mon_edges = 0, gap_bad = 0, exp_half = 1;
    logic        prev_sck = 1'b0, cfg_idle = 1'b0, cfg_early = 1'b1;
    logic [31:0] cap_word = '0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (sck !== prev_sck) begin
            if ((sck != cfg_idle) == cfg_early) cap_word <= {cap_word[30:0], mosi};
            if (mon_edges > 0 && (cyc - last_edge) != exp_half) gap_bad <= gap_bad + 1;
            last_edge <= cyc;
            mon_edges <= mon_edges + 1;
        end
        prev_sck <= sck;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_rx(input int n);
        logic [31:0] s;
        for (int k = 0; k < 4000; k++) begin
            rd(A_STAT, s);
            if (int'(s[28:24]) >= n) break;
        end
    endtask

    task automatic mon_clear();
        @(negedge clk);
        #1;
        mon_edges = 0; gap_bad = 0; cap_word = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, m, ctl;
        int nb;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_CTRL, v); check("R1 ctrl", v, 32'h0);
        rd(A_STAT, v); check("R1 stat", v, 32'h0);
        rd(A_DIV, v);  check("R1 div", v, 32'h0);
        check("R1 sck", {31'b0, sck}, 32'd0);
        check("R1 ss_n", {31'b0, ss_n}, 32'd1);

        // table of transfers
        for (int i = 0; i < NV; i++) begin
            nb = 8 << VEC[i][45:44];
            m  = (nb == 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 1);
            cfg_idle = VEC[i][43]; cfg_early = VEC[i][42];
            exp_half = int'(VEC[i][40:32]) + 1;
            wr(A_CTRL, 32'h0);
            wr(A_DIV, {23'b0, VEC[i][40:32]});
            ctl = B_ON | B_MST | B_DEEP | B_AUTO | (32'(VEC[i][45:44]) << 10) |
                  (32'(VEC[i][43]) << 6) | (32'(VEC[i][42]) << 8) | (32'(VEC[i][41]) << 9);
            wr(A_CTRL, ctl);
            repeat (3) @(negedge clk);
            check("R4 idle level", {31'b0, sck}, {31'b0, VEC[i][43]});
            mon_clear();
            wr(A_DATA, VEC[i][31:0]);
            check("R10 ss low with queued word", {31'b0, ss_n}, 32'd0);
            wait_rx(1);
            rd(A_DATA, v);
            check("R6 received word", v, ~VEC[i][31:0] & m);
            check("R5 R3 mosi word msb first", cap_word & m, VEC[i][31:0] & m);
            check("R3 edge count", 32'(mon_edges), 32'(2 * nb));
            check("R2 half period", 32'(gap_bad), 32'd0);
            check("R10 ss high after drain", {31'b0, ss_n}, 32'd1);
            check("R4 idle after word", {31'b0, sck}, {31'b0, VEC[i][43]});
        end

        // R7 capacities, R11 no shifting without master
        cfg_idle = 1'b0;
        for (int w = 0; w < 4; w++) begin
            wr(A_CTRL, 32'h0);
            ctl = (w == 3) ? B_ON : (B_ON | B_DEEP | (32'(w) << 10));
            wr(A_CTRL, ctl);
            mon_clear();
            for (int k = 0; k < 20; k++) wr(A_DATA, 32'(k));
            rd(A_STAT, v);
            check("R7 tx level at capacity", {27'b0, v[20:16]},
                  (w == 3) ? 32'd1 : (32'd16 >> w));
        end
        repeat (100) @(negedge clk);
        check("R11 no clock without master", 32'(mon_edges), 32'd0);
        rd(A_STAT, v); check("R11 word kept without master", {27'b0, v[20:16]}, 32'd1);
        wr(A_CTRL, 32'h0);
        rd(A_STAT, v); check("R11 disable flushes", {27'b0, v[20:16]}, 32'd0);

        // R9 aliases
        wr(A_CTRL_SET, B_ON | B_DEEP | B_AUTO);
        rd(A_CTRL, v); check("R9 ctrl set alias", v, B_ON | B_DEEP | B_AUTO);
        wr(A_CTRL_CLR, B_AUTO);
        rd(A_CTRL, v); check("R9 ctrl clear alias", v, B_ON | B_DEEP);
        wr(A_DIV, 32'd5); wr(A_DIV_SET, 32'd2);
        rd(A_DIV, v); check("R9 div set alias", v, 32'd7);
        wr(A_DIV_CLR, 32'd1);
        rd(A_DIV, v); check("R9 div clear alias", v, 32'd6);

        // R8 overflow, R7 order
        wr(A_CTRL, 32'h0); wr(A_DIV, 32'd0);
        cfg_early = 1'b1; exp_half = 1;
        wr(A_CTRL, B_ON | B_MST | B_DEEP | (32'd1 << 8));
        for (int k = 0; k < 17; k++) wr(A_DATA, 32'(k));
        repeat (400) @(negedge clk);
        rd(A_STAT, v);
        check("R8 rx level full", {27'b0, v[28:24]}, 32'd16);
        check("R8 overflow set", {31'b0, v[6]}, 32'd1);
        rd(A_DATA, v); check("R7 first word out first", v, 32'hFF);
        rd(A_DATA, v); check("R7 second word next", v, 32'hFE);
        rd(A_STAT, v); check("R8 flag sticky over reads", {31'b0, v[6]}, 32'd1);
        wr(A_STAT_CLR, 32'h40);
        rd(A_STAT, v); check("R8 cleared by alias", {31'b0, v[6]}, 32'd0);

        // R10 automatic select off
        wr(A_CTRL, 32'h0); wr(A_DIV, 32'd3);
        wr(A_CTRL, B_ON | B_MST | B_DEEP | (32'd1 << 8));
        wr(A_DATA, 32'h5A);
        repeat (10) @(negedge clk);
        check("R10 ss stays high when off", {31'b0, ss_n}, 32'd1);
        wait_rx(1);
        rd(A_DATA, v); check("R6 word with select off", v, 32'hA5);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule